// File: doc/BRIEF.md
# Pulse-Width Coded Single-Wire Bus Slave

This block is a slave endpoint on a single-wire, open-drain bus. On that bus every symbol is a low pulse whose length encodes its meaning. The master opens every pulse. The slave measures how long the line stays low and turns each low pulse into a sync marker, a 0 or a 1. It detects the pause preamble that starts a frame and collects the 8-bit header: the direction flag, a 3-bit device address and a 4-bit register field. It then checks the header parity bit.

When the header is addressed to this device, the slave does one of two things. On a write it receives a data byte and its parity bit, stores the byte in an eight-entry register file and acknowledges. On a read it answers in slots that the master opens. The slave stretches each master pulse to the width of the bit it is sending: eight data bits, a parity bit and then an acknowledge. The only way the slave touches the bus is through a pull-down enable. A host-side read port exposes the register file, and a write strobe reports every update.

Top module: `pwb_slave`

## Requirements
- R1: Symbols are classified from the low width L of the line, with U = UNIT_CLKS clocks per unit: L < 2U is a sync, 2U <= L < 4.5U is a 0, and L >= 4.5U is a 1. Nominal widths are 1U, 3U and 6U.
- R2: Three or more consecutive sync pulses arm a new frame. Extra syncs after the third are absorbed. Two syncs followed by a data bit arm nothing.
- R3: After the pause, the first eight data bits form the header in this order: the direction flag first, then the device address MSB first, then the register field MSB first. Only direction 0 (master request) is served.
- R4: The ninth bit is the header parity and must equal the XOR of the eight header bits. If it does not, the frame is ignored.
- R5: A frame whose device address differs from dev_addr_i is ignored: nothing is written and the line is never pulled.
- R6: Bit 3 of the register field set selects a write. The eight data bits, MSB first, are stored in entry field[2:0] when the data parity bit equals the XOR of the byte. wr_stb_o pulses for exactly one cycle, with wr_idx_o and wr_data_o valid in that cycle.
- R7: In the acknowledge slot of a write, a good data parity makes the slave stretch the master pulse to a 0 (3U). A bad data parity leaves the slot unstretched, so it reads as a sync, and leaves the register unchanged.
- R8: Bit 3 of the register field clear selects a read. Entry field[2:0] is returned MSB first. Each bit goes in the next master-opened slot: the slave starts pulling before one unit has passed and releases so that the total low time is 3U for a 0 and 6U for a 1.
- R9: A read ends with a slot carrying the XOR of the returned byte, then an acknowledge slot driven as 0.
- R10: A sync pulse that arrives during the header, the header parity or the write data aborts the frame. That sync counts as the first sync of a new pause.
- R11: pull_o never stays asserted for more than 6U consecutive cycles, and it rises only in the cycle after a falling edge of the synchronized line.
- R12: After reset pull_o is 0 and all eight register entries read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Bus line level (1 = released, 0 = low) |
| dev_addr_i | input | 3 | Device address this slave answers to |
| pull_o | output | 1 | Pull-down enable for the bus line |
| host_idx_i | input | 3 | Host read port entry index |
| host_data_o | output | 8 | Host read port data (combinational) |
| wr_stb_o | output | 1 | One-cycle pulse when an entry is written from the bus |
| wr_idx_o | output | 3 | Index of the entry being written |
| wr_data_o | output | 8 | Byte being written |

## Verification
The checker watches four things on every cycle: that the pull-down never outlasts the longest bit width, that it only starts right after the line has been seen falling, that the write strobe is a single-cycle pulse that never overlaps the slave driving the line, and that the line is quiet right after reset. Everything else needs whole frames, so only the bench scenarios can show it. That covers classification near the thresholds, pause counting, address and parity rejection, abort on a stray sync, the exact bit values returned in read slots and the acknowledge outcome of writes. The bench plays the master over a wired-AND line model and measures every slot's low width.

// File: rtl/pwb_pkg.sv
// Package: shared constants and types for the pulse-width bus slave.
// Assumes an 8-bit header (1 direction, 3 address, 4 register bits) and an 8-bit data byte.
package pwb_pkg;
    localparam int DATA_W   = 8;
    localparam int HDR_W    = 8;
    localparam int DEV_W    = 3;
    localparam int IDX_W    = 3;
    localparam int NREGS    = 1 << IDX_W;
    localparam int SYNC_LAT = 3;

    typedef enum logic [1:0] {
        SYM_SYNC = 2'd0,
        SYM_ZERO = 2'd1,
        SYM_ONE  = 2'd2
    } sym_e;

    typedef enum logic [3:0] {
        F_IDLE,
        F_PAUSE,
        F_HDR,
        F_P1,
        F_WDATA,
        F_WP2,
        F_WACK,
        F_RDATA,
        F_RP2,
        F_RACK
    } fstate_e;

    // Odd-count indicator: 1 when the byte holds an odd number of ones.
    function automatic logic odd_ind(input logic [DATA_W-1:0] v);
        return ^v;
    endfunction
endpackage

// File: rtl/pwb_line_sync.sv
// Line synchronizer: two-flop synchronizer on the raw bus level plus edge flags.
// Assumes the line idles high; reset values model a released bus.
module pwb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic fall,
    output logic rise
);
    logic s1, s2, s3;

    // Purpose: resynchronize the line and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign line_s = s2;
    assign fall   = s3 & ~s2;
    assign rise   = ~s3 & s2;
endmodule

// File: rtl/pwb_pulse_meter.sv
// Pulse meter: counts the synchronized low time and classifies it on release.
// Thresholds sit halfway between nominal widths; the count saturates at 8 units.
module pwb_pulse_meter
    import pwb_pkg::*;
#(
    parameter int UNIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic rise,
    output logic sym_vld,
    output sym_e sym_kind
);
    localparam int CNT_MAX = 8 * UNIT_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TH_ZERO = CNT_W'(2 * UNIT_CLKS);
    localparam logic [CNT_W-1:0] TH_ONE  = CNT_W'((9 * UNIT_CLKS) / 2);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] low_cnt;
    sym_e             kind_c;

    // Purpose: measure the current low period, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!line_s) begin
            if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    // Purpose: map the measured width to a symbol kind.
    always_comb begin
        if (low_cnt < TH_ZERO)     kind_c = SYM_SYNC;
        else if (low_cnt < TH_ONE) kind_c = SYM_ZERO;
        else                       kind_c = SYM_ONE;
    end

    // Purpose: register one symbol event per release of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_vld  <= 1'b0;
            sym_kind <= SYM_SYNC;
        end else begin
            sym_vld <= rise;
            if (rise) sym_kind <= kind_c;
        end
    end
endmodule

// File: rtl/pwb_slot_driver.sv
// Slot driver: stretches a master-opened slot by holding the pull-down.
// Assumes start arrives SYNC_LAT cycles after the master's edge; the hold is shortened by that latency.
module pwb_slot_driver
    import pwb_pkg::*;
#(
    parameter int UNIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    input  logic long_bit,
    output logic pull
);
    localparam int HOLD_W = $clog2(6 * UNIT_CLKS + 1);
    localparam logic [HOLD_W-1:0] HOLD0 = HOLD_W'(3 * UNIT_CLKS - SYNC_LAT);
    localparam logic [HOLD_W-1:0] HOLD1 = HOLD_W'(6 * UNIT_CLKS - SYNC_LAT);

    logic [HOLD_W-1:0] remain;

    // Purpose: run the hold counter and the pull-down enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            pull   <= en;
            remain <= (long_bit ? HOLD1 : HOLD0) - 1'b1;
        end else if (pull) begin
            if (remain == '0) pull <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/pwb_regfile.sv
// Register file: NREGS entries of DATA_W bits, one write port and two combinational read ports.
// Assumes at most one write per cycle; all entries clear on reset.
module pwb_regfile
    import pwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        // Purpose: hold one entry, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[g] <= '0;
            else if (we && widx == IDX_W'(g))    mem[g] <= wdata;
        end
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
endmodule

// File: rtl/pwb_frame_ctrl.sv
// Frame controller: pause detection, header capture, parity checks, write commit
// and sequencing of answer slots. Assumes one symbol event per low pulse.
module pwb_frame_ctrl
    import pwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic              sym_vld,
    input  sym_e              sym_kind,
    input  logic              line_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rf_idx,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              drv_start,
    output logic              drv_en,
    output logic              drv_long
);
    fstate_e           state;
    logic [1:0]        sync_cnt;
    logic [HDR_W-1:0]  hdr;
    logic [DATA_W-1:0] dat;
    logic [2:0]        bit_cnt;
    logic              rpar;
    logic              ack_ok;
    logic              is_sync;
    logic              bit_v;
    logic              hdr_ok;
    logic              tx_state;

    assign is_sync = (sym_kind == SYM_SYNC);
    assign bit_v   = (sym_kind == SYM_ONE);
    assign hdr_ok  = !hdr[HDR_W-1] && (hdr[6:4] == dev_addr);
    assign rf_idx  = hdr[IDX_W-1:0];

    // Purpose: advance the frame state on each classified symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= F_IDLE;
            sync_cnt <= '0;
            hdr      <= '0;
            dat      <= '0;
            bit_cnt  <= '0;
            rpar     <= 1'b0;
            ack_ok   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (sym_vld) begin
                case (state)
                    F_IDLE: begin
                        if (is_sync) begin
                            if (sync_cnt == 2'd2) begin
                                state    <= F_PAUSE;
                                sync_cnt <= '0;
                            end else begin
                                sync_cnt <= sync_cnt + 1'b1;
                            end
                        end else begin
                            sync_cnt <= '0;
                        end
                    end
                    F_PAUSE: begin
                        if (!is_sync) begin
                            hdr     <= {hdr[HDR_W-2:0], bit_v};
                            bit_cnt <= 3'd1;
                            state   <= F_HDR;
                        end
                    end
                    F_HDR: begin
                        if (is_sync) begin
                            state    <= F_IDLE;
                            sync_cnt <= 2'd1;
                        end else begin
                            hdr <= {hdr[HDR_W-2:0], bit_v};
                            if (bit_cnt == 3'd7) state <= F_P1;
                            else                 bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    F_P1: begin
                        if (is_sync) begin
                            state    <= F_IDLE;
                            sync_cnt <= 2'd1;
                        end else if (hdr_ok && (bit_v == odd_ind(hdr))) begin
                            bit_cnt <= '0;
                            if (hdr[3]) begin
                                state <= F_WDATA;
                            end else begin
                                dat   <= rd_data;
                                rpar  <= odd_ind(rd_data);
                                state <= F_RDATA;
                            end
                        end else begin
                            state    <= F_IDLE;
                            sync_cnt <= '0;
                        end
                    end
                    F_WDATA: begin
                        if (is_sync) begin
                            state    <= F_IDLE;
                            sync_cnt <= 2'd1;
                        end else begin
                            dat <= {dat[DATA_W-2:0], bit_v};
                            if (bit_cnt == 3'd7) state <= F_WP2;
                            else                 bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    F_WP2: begin
                        if (is_sync) begin
                            state    <= F_IDLE;
                            sync_cnt <= 2'd1;
                        end else begin
                            ack_ok  <= (bit_v == odd_ind(dat));
                            wr_stb  <= (bit_v == odd_ind(dat));
                            wr_idx  <= hdr[IDX_W-1:0];
                            wr_data <= dat;
                            state   <= F_WACK;
                        end
                    end
                    F_RDATA: begin
                        dat <= {dat[DATA_W-2:0], 1'b0};
                        if (bit_cnt == 3'd7) state <= F_RP2;
                        else                 bit_cnt <= bit_cnt + 1'b1;
                    end
                    F_RP2: state <= F_RACK;
                    F_WACK, F_RACK: begin
                        state    <= F_IDLE;
                        sync_cnt <= '0;
                    end
                    default: begin
                        state    <= F_IDLE;
                        sync_cnt <= '0;
                    end
                endcase
            end
        end
    end

    // Purpose: choose the value to place in the next master-opened slot.
    always_comb begin
        tx_state = 1'b0;
        drv_en   = 1'b0;
        drv_long = 1'b0;
        case (state)
            F_WACK:  begin tx_state = 1'b1; drv_en = ack_ok; end
            F_RDATA: begin tx_state = 1'b1; drv_en = 1'b1; drv_long = dat[DATA_W-1]; end
            F_RP2:   begin tx_state = 1'b1; drv_en = 1'b1; drv_long = rpar; end
            F_RACK:  begin tx_state = 1'b1; drv_en = 1'b1; end
            default: ;
        endcase
    end

    assign drv_start = tx_state && line_fall;
endmodule

// File: rtl/pwb_slave.sv
// Top: pulse-width coded single-wire bus slave with an eight-entry register file.
// Assumes UNIT_CLKS >= 4 so the slave starts pulling well inside the master's sync time.
module pwb_slave
    import pwb_pkg::*;
#(
    parameter int UNIT_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [DEV_W-1:0]  dev_addr_i,
    output logic              pull_o,
    input  logic [IDX_W-1:0]  host_idx_i,
    output logic [DATA_W-1:0] host_data_o,
    output logic              wr_stb_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o
);
    logic              line_s;
    logic              line_fall;
    logic              line_rise;
    logic              sym_vld;
    sym_e              sym_kind;
    logic [IDX_W-1:0]  rf_idx;
    logic [DATA_W-1:0] rf_rdata;
    logic              drv_start;
    logic              drv_en;
    logic              drv_long;

    pwb_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .line_s (line_s),
        .fall   (line_fall),
        .rise   (line_rise)
    );

    pwb_pulse_meter #(.UNIT_CLKS(UNIT_CLKS)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .rise     (line_rise),
        .sym_vld  (sym_vld),
        .sym_kind (sym_kind)
    );

    pwb_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr_i),
        .sym_vld   (sym_vld),
        .sym_kind  (sym_kind),
        .line_fall (line_fall),
        .rd_data   (rf_rdata),
        .rf_idx    (rf_idx),
        .wr_stb    (wr_stb_o),
        .wr_idx    (wr_idx_o),
        .wr_data   (wr_data_o),
        .drv_start (drv_start),
        .drv_en    (drv_en),
        .drv_long  (drv_long)
    );

    pwb_slot_driver #(.UNIT_CLKS(UNIT_CLKS)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (drv_start),
        .en       (drv_en),
        .long_bit (drv_long),
        .pull     (pull_o)
    );

    pwb_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_stb_o),
        .widx    (wr_idx_o),
        .wdata   (wr_data_o),
        .ra_idx  (rf_idx),
        .ra_data (rf_rdata),
        .rb_idx  (host_idx_i),
        .rb_data (host_data_o)
    );
endmodule

// File: rtl/pwb_slave_checker.sv
// Checker: cycle-level properties of the slave, attached to pwb_slave by bind.
// Assumes the synchronized falling-edge flag of the top is visible as line_fall.
module pwb_slave_checker #(
    parameter int UNIT_CLKS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic pull_o,
    input logic wr_stb_o,
    input logic line_fall
);
    localparam int RUN_W = $clog2(8 * UNIT_CLKS + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(6 * UNIT_CLKS);

    logic [RUN_W-1:0] pull_run;

    // Purpose: count consecutive cycles with the pull-down enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      pull_run <= '0;
        else if (pull_o) pull_run <= (pull_run == '1) ? pull_run : pull_run + 1'b1;
        else             pull_run <= '0;
    end

    // R11: the pull-down never outlasts the longest bit width
    a_r11_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= RUN_MAX);

    // R11 / R8: the pull-down only starts right after a master-opened slot
    a_r11_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_o) |-> $past(line_fall));

    // R6: a write strobe lasts exactly one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R6: data is never committed while the slave drives the line
    a_r6_no_write_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !pull_o);

    // R12: the line is released in the first cycle after reset
    a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pull_o && !wr_stb_o));
endmodule

bind pwb_slave pwb_slave_checker #(.UNIT_CLKS(UNIT_CLKS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pull_o    (pull_o),
    .wr_stb_o  (wr_stb_o),
    .line_fall (line_fall)
);

// File: tb/test_pwb_slave.sv
// Bench: plays the bus master over a wired-AND line; a monitor measures every
// answer slot and compares its class against a scoreboard queue.
module test_pwb_slave;
    localparam int U      = 8;
    localparam int GAP    = 2 * U;
    localparam int K_SYNC = 0;
    localparam int K_ZERO = 1;
    localparam int K_ONE  = 2;
    localparam logic [2:0] MY_ADDR = 3'd5;

    typedef struct {
        int    kind;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_low = 1'b0;
    logic       watch = 1'b0;
    logic       line;
    logic       pull_o;
    logic [2:0] host_idx = 3'd0;
    logic [7:0] host_data;
    logic       wr_stb;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    int w_sync = U;
    int w_zero = 3 * U;
    int w_one = 6 * U;
    int low_len = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    assign line = ~(master_low | pull_o);

    pwb_slave #(.UNIT_CLKS(U)) i_pwb_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .dev_addr_i  (MY_ADDR),
        .pull_o      (pull_o),
        .host_idx_i  (host_idx),
        .host_data_o (host_data),
        .wr_stb_o    (wr_stb),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data)
    );

    function automatic int classify(input int len);
        if (len < 2 * U)       return K_SYNC;
        if (len < (9 * U) / 2) return K_ONE - 1;
        return K_ONE;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: measure each watched low pulse and pop the scoreboard.
    always @(negedge clk) begin
        if (wr_stb) wr_count++;
        if (!line) begin
            low_len++;
        end else begin
            if (low_len > 0 && watch) begin
                if (sb.size() == 0) begin
                    check(1'b0, "unexpected slot", classify(low_len), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(classify(low_len) == e.kind, e.tag, classify(low_len), e.kind);
                end
            end
            low_len = 0;
        end
    end

    task automatic master_pulse(input int low_clk);
        @(negedge clk) master_low = 1'b1;
        repeat (low_clk) @(negedge clk);
        master_low = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        master_pulse(b ? w_one : w_zero);
    endtask

    task automatic slot(input int exp_kind, input string tag);
        exp_t e;
        e.kind = exp_kind;
        e.tag  = tag;
        sb.push_back(e);
        watch = 1'b1;
        @(negedge clk) master_low = 1'b1;
        repeat (U) @(negedge clk);
        master_low = 1'b0;
        do @(negedge clk); while (!line);
        repeat (2) @(negedge clk);
        watch = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    // Driver: one master frame; abort_at >= 0 inserts a sync after that many header bits.
    task automatic frame(input int npause, input bit dir, input logic [2:0] addr,
                         input logic [3:0] rg, input logic [7:0] dat, input bit p1_bad,
                         input bit p2_bad, input int ack_kind, input int abort_at,
                         input string tag);
        logic [7:0] h;
        h = {dir, addr, rg};
        for (int i = 0; i < npause; i++) master_pulse(w_sync);
        for (int i = 7; i >= 0; i--) begin
            if (abort_at == 7 - i) master_pulse(w_sync);
            send_bit(h[i]);
        end
        send_bit((^h) ^ p1_bad);
        if (rg[3]) begin
            for (int i = 7; i >= 0; i--) send_bit(dat[i]);
            send_bit((^dat) ^ p2_bad);
            slot(ack_kind, tag);
        end else begin
            for (int i = 7; i >= 0; i--)
                slot((ack_kind == K_SYNC) ? K_SYNC : (dat[i] ? K_ONE : K_ZERO), tag);
            slot((ack_kind == K_SYNC) ? K_SYNC : ((^dat) ? K_ONE : K_ZERO), {tag, " parity"});
            slot(ack_kind, {tag, " ack"});
        end
        repeat (4 * U) @(negedge clk);
    endtask

    task automatic check_reg(input logic [2:0] idx, input logic [7:0] exp, input string tag);
        @(negedge clk) host_idx = idx;
        #1;
        check(host_data == exp, tag, host_data, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12: released line and cleared file after reset
        check(pull_o == 1'b0, "R12 pull after reset", pull_o, 0);
        for (int i = 0; i < 8; i++) check_reg(3'(i), 8'h00, "R12 entry after reset");

        // R3 R6 R7: good write to entry 3, acknowledged with a stretched 0
        frame(3, 1'b0, MY_ADDR, 4'b1011, 8'hA5, 1'b0, 1'b0, K_ZERO, -1, "R7 write ack");
        check_reg(3'd3, 8'hA5, "R6 entry 3 after write");
        check(wr_count == 1, "R6 strobe count", wr_count, 1);

        // R8 R9: read entry 3 back slot by slot
        frame(3, 1'b0, MY_ADDR, 4'b0011, 8'hA5, 1'b0, 1'b0, K_ZERO, -1, "R8 read entry 3");

        // R2: long pause of five syncs still arms the frame
        frame(5, 1'b0, MY_ADDR, 4'b1000, 8'h3C, 1'b0, 1'b0, K_ZERO, -1, "R2 long pause ack");
        check_reg(3'd0, 8'h3C, "R2 entry 0 after long pause");

        // R5: another device address, ignored
        frame(3, 1'b0, 3'd2, 4'b1011, 8'hFF, 1'b0, 1'b0, K_SYNC, -1, "R5 foreign ack");
        check_reg(3'd3, 8'hA5, "R5 entry 3 untouched");

        // R4: bad header parity, ignored
        frame(3, 1'b0, MY_ADDR, 4'b1011, 8'h00, 1'b1, 1'b0, K_SYNC, -1, "R4 bad header parity ack");
        check_reg(3'd3, 8'hA5, "R4 entry 3 untouched");

        // R7: bad data parity, unstretched ack and no write
        frame(3, 1'b0, MY_ADDR, 4'b1011, 8'h11, 1'b0, 1'b1, K_SYNC, -1, "R7 bad data parity ack");
        check_reg(3'd3, 8'hA5, "R7 entry 3 untouched");
        check(wr_count == 2, "R7 strobe count", wr_count, 2);

        // R3: direction flag 1 is not served
        frame(3, 1'b1, MY_ADDR, 4'b1011, 8'h22, 1'b0, 1'b0, K_SYNC, -1, "R3 dir one ack");
        check_reg(3'd3, 8'hA5, "R3 entry 3 untouched");

        // R2: two syncs after a data bit do not arm a frame
        send_bit(1'b0);
        frame(2, 1'b0, MY_ADDR, 4'b1011, 8'h77, 1'b0, 1'b0, K_SYNC, -1, "R2 short pause ack");
        check_reg(3'd3, 8'hA5, "R2 entry 3 untouched");

        // R10: stray sync inside the header aborts the frame
        frame(3, 1'b0, MY_ADDR, 4'b1011, 8'h99, 1'b0, 1'b0, K_SYNC, 4, "R10 aborted ack");
        check_reg(3'd3, 8'hA5, "R10 entry 3 untouched");

        // R1: off-nominal widths just inside the thresholds
        w_sync = (3 * U) / 2;
        w_zero = 4 * U;
        w_one  = 5 * U;
        frame(3, 1'b0, MY_ADDR, 4'b1110, 8'hC3, 1'b0, 1'b0, K_ZERO, -1, "R1 skewed write ack");
        check_reg(3'd6, 8'hC3, "R1 entry 6 after skewed write");
        w_sync = U;
        w_zero = 3 * U;
        w_one  = 6 * U;

        // R8 R9: read entry 0 and entry 6
        frame(3, 1'b0, MY_ADDR, 4'b0000, 8'h3C, 1'b0, 1'b0, K_ZERO, -1, "R8 read entry 0");
        frame(3, 1'b0, MY_ADDR, 4'b0110, 8'hC3, 1'b0, 1'b0, K_ZERO, -1, "R9 read entry 6");

        check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
        check(wr_count == 3, "R6 final strobe count", wr_count, 3);
        finish_run();
    end
endmodule